// File: doc/BRIEF.md
# Prefix-OR Leading-One Mask Encoder

This block turns an n-bit vector into a thermometer mask that marks the first set bit and every position after it. Positions are counted from 1 at the most significant bit of `in_vec` (bit n-1) down to n at bit 0. Mask position i is the OR of input positions 1 through i. The mask is zero before the leading one and one from the leading one onward. A floating-point adder uses this mask to steer the left shift that normalizes a sum after cancellation.

The OR network is a recursive pairwise prefix tree. The first level ORs neighbouring position pairs (1,2), (3,4) and so on. It hands the n/2 pair results to a half-width copy of itself. Even positions take their value straight from the half-width result. Each odd position 2j+1 ORs the half-width result for pair j with its own input bit, and position 1 passes through unchanged. The recursion stops at width 2. Gate count grows linearly with n and depth grows with log n.

For timing work the network sits between an input register stage and an output register stage. A valid flag travels alongside the data. A new vector may be accepted on every clock.

Top module: `thermo_mask_enc`

## Requirements
- R1: Mask position i (position 1 = `in_vec[N-1]`, position N = `in_vec[0]`) equals the OR of input positions 1 through i, for every input value.
- R2: With N=4, the input positions 1..4 = 0,0,1,0 (`in_vec` = 4'b0010) produce the mask 4'b0011.
- R3: An all-zero input produces an all-zero mask.
- R4: An input whose position 1 (`in_vec[N-1]`) is set produces an all-ones mask, whatever the other bits are.
- R5: Every mask is a thermometer code: once a position is 1, every later position is 1 as well. In the vector this means the mask has the form 0…01…1.
- R6: A vector accepted with `in_valid`=1 at a rising edge appears on `out_mask` with `out_valid`=1 exactly two rising edges later. Back-to-back vectors come out in order, one per cycle. No `out_valid` appears without a matching accepted input.
- R7: While `rst_n` is low and after it is released, and before any vector has passed through, `out_valid` and `out_mask` are 0.
- R8: Mask position N (`out_mask[0]`) is 1 exactly when any input bit is set.
- R9: The function holds for every power-of-two width N from 2 to 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is present this cycle |
| in_vec | input | N | Vector to scan; bit N-1 is position 1 |
| out_valid | output | 1 | `out_mask` holds a result |
| out_mask | output | N | Thermometer mask from the leading one down to bit 0 |

## Verification
The bench tries every input value at widths 2, 4 and 16. At width 64 it drives a leading one at every position, with random bits below it, plus random vectors. A wrong pair split or a wrong odd-position merge would leave holes inside the run of ones or make the mask start one place late. The zero and MSB-set inputs are aimed at a recursion that drops its first position or its last pair, which would leave the mask partly clear. Idle gaps mixed with back-to-back vectors catch a valid flag that leaves the data pipe too early or too late; such a fault would show up as missing, extra or misordered results.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    // Width at which the recursive prefix network stops splitting.
    localparam int LEAF_W = 2;
    // Latency from an accepted input to its result, in clock edges.
    localparam int PIPE_LAT = 2;
endpackage

// File: rtl/pfx_pair_or.sv
module pfx_pair_or #(
    parameter int H = 8
) (
    input  logic [2*H-1:0] x,
    output logic [H-1:0]   p
);
    // Index 0 is the earliest position; pair j covers positions 2j and 2j+1.
    for (genvar j = 0; j < H; j++) begin : g_pair
        assign p[j] = x[2*j] | x[2*j+1];
    end
endmodule

// File: rtl/pfx_or_net.sv
module pfx_or_net
    import pfx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] x,
    output logic [N-1:0] a
);
    localparam int H = N / 2;

    if (N <= LEAF_W) begin : g_leaf
        assign a[0] = x[0];
        assign a[1] = x[0] | x[1];
    end else begin : g_rec
        logic [H-1:0] pair_or;
        logic [H-1:0] half_pfx;

        pfx_pair_or #(.H(H)) u_pair (
            .x (x),
            .p (pair_or)
        );

        pfx_or_net #(.N(H)) u_half (
            .x (pair_or),
            .a (half_pfx)
        );

        for (genvar j = 0; j < H; j++) begin : g_merge
            // Second member of each pair: prefix of whole pairs 0..j.
            assign a[2*j+1] = half_pfx[j];
            if (j == 0) begin : g_first
                assign a[0] = x[0];
            end else begin : g_odd
                // First member: prefix of pairs before it plus itself.
                assign a[2*j] = half_pfx[j-1] | x[2*j];
            end
        end
    end
endmodule

// File: rtl/thermo_mask_enc.sv
module thermo_mask_enc
    import pfx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] in_vec,
    output logic         out_valid,
    output logic [N-1:0] out_mask
);
    logic         vld_q;
    logic [N-1:0] vec_q;
    logic [N-1:0] pos_in;
    logic [N-1:0] pos_pfx;
    logic [N-1:0] mask_d;

    // Input stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            vec_q <= '0;
        end else begin
            vld_q <= in_valid;
            vec_q <= in_vec;
        end
    end

    // Reorder so index 0 is position 1 (the MSB), then back again.
    for (genvar k = 0; k < N; k++) begin : g_order
        assign pos_in[k]      = vec_q[N-1-k];
        assign mask_d[N-1-k]  = pos_pfx[k];
    end

    pfx_or_net #(.N(N)) u_net (
        .x (pos_in),
        .a (pos_pfx)
    );

    // Output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else begin
            out_valid <= vld_q;
            out_mask  <= mask_d;
        end
    end

    // R5
    mask_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & (out_mask + 1'b1)) == '0));

    // R6
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, PIPE_LAT));

    // R3
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_vec, PIPE_LAT) == '0) |-> (out_mask == '0));

    // R4
    msb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_vec[N-1], PIPE_LAT)) |-> (&out_mask));

    // R8
    tail_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask[0] == $past(|in_vec, PIPE_LAT)));

    // R7
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_mask == '0));
endmodule

// File: tb/sim_thermo_mask_enc.sv
module sim_thermo_mask_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  vld = '0;
    logic [63:0] stim = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic        ov0, ov1, ov2, ov3;
    logic [15:0] om0;
    logic [3:0]  om1;
    logic [1:0]  om2;
    logic [63:0] om3;

    logic [63:0] expq [4][$];
    logic [63:0] inq  [4][$];
    string       tagq [4][$];

    always #10 clk = ~clk;  // 50 MHz

    thermo_mask_enc #(.N(16)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(vld[0]),
        .in_vec(stim[15:0]), .out_valid(ov0), .out_mask(om0));
    thermo_mask_enc #(.N(4))  u1 (.clk(clk), .rst_n(rst_n), .in_valid(vld[1]),
        .in_vec(stim[3:0]),  .out_valid(ov1), .out_mask(om1));
    thermo_mask_enc #(.N(2))  u2 (.clk(clk), .rst_n(rst_n), .in_valid(vld[2]),
        .in_vec(stim[1:0]),  .out_valid(ov2), .out_mask(om2));
    thermo_mask_enc #(.N(64)) u3 (.clk(clk), .rst_n(rst_n), .in_valid(vld[3]),
        .in_vec(stim),       .out_valid(ov3), .out_mask(om3));

    function automatic logic [63:0] ref_mask(logic [63:0] v, int n);
        logic [63:0] r = '0;
        logic run = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            run  = run | v[i];
            r[i] = run;
        end
        return r;
    endfunction

    function automatic logic [63:0] width_ones(int n);
        return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send(int idx, logic [63:0] v, int n);
        string tag;
        logic [63:0] vv = v & width_ones(n);
        if (vv == 0)                      tag = "R3";
        else if (vv[n-1])                 tag = "R4";
        else if (n == 4 && vv == 64'h2)   tag = "R2";
        else if (n == 2)                  tag = "R9";
        else                              tag = "R1";
        stim = vv;
        vld[idx] = 1'b1;
        expq[idx].push_back(ref_mask(vv, n));
        inq[idx].push_back(vv);
        tagq[idx].push_back(tag);
        @(posedge clk); #1;
        vld[idx] = 1'b0;
    endtask

    task automatic idle(int cycles);
        for (int c = 0; c < cycles; c++) begin
            stim = {$urandom, $urandom};
            @(posedge clk); #1;
        end
    endtask

    task automatic compare(int idx, logic [63:0] got, int n);
        logic [63:0] e, v;
        string t;
        if (expq[idx].size() == 0) begin
            check(1'b0, "R6 unexpected out_valid", got, 64'h0);
            return;
        end
        e = expq[idx].pop_front();
        v = inq[idx].pop_front();
        t = tagq[idx].pop_front();
        check(got == e, t, got, e);
        // R5 thermometer shape
        check(((got & (got + 64'd1)) & width_ones(n)) == 0, "R5", got, e);
        // R8 tail bit follows any-set
        check(got[0] == (v != 0), "R8", {63'b0, got[0]}, {63'b0, (v != 0)});
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ov0) compare(0, {48'b0, om0}, 16);
            if (ov1) compare(1, {60'b0, om1}, 4);
            if (ov2) compare(2, {62'b0, om2}, 2);
            if (ov3) compare(3, om3, 64);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        // R7 during reset
        check({ov0, ov1, ov2, ov3} == 0 && om0 == 0 && om1 == 0 && om2 == 0 && om3 == 0,
              "R7", {ov0, ov1, ov2, ov3}, 64'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R7 after release, nothing sent
        check({ov0, ov1, ov2, ov3} == 0 && om3 == 0, "R7", {60'b0, ov0, ov1, ov2, ov3}, 64'h0);
        @(posedge clk); #1;

        // R9 smallest width, exhaustive
        for (int v = 0; v < 4; v++) send(2, 64'(v), 2);
        idle(3);
        // R2 and exhaustive width 4 (includes 4'b0010)
        for (int v = 0; v < 16; v++) send(1, 64'(v), 4);
        send(1, 64'h2, 4);
        idle(3);
        // R1 exhaustive width 16, with R6 idle gaps
        for (int v = 0; v < 65536; v++) begin
            send(0, 64'(v), 16);
            if (v % 4099 == 0) idle(2);
        end
        idle(3);
        // R9 width 64: leading one at every position, random tail
        for (int k = 0; k < 64; k++) begin
            logic [63:0] lead = 64'd1 << k;
            send(3, lead | ({$urandom, $urandom} & (lead - 64'd1)), 64);
        end
        send(3, 64'h0, 64);
        send(3, 64'h1, 64);
        send(3, 64'h8000_0000_0000_0000, 64);
        for (int r = 0; r < 1500; r++) begin
            send(3, {$urandom, $urandom}, 64);
            if (r % 97 == 0) idle(1);
        end
        idle(4);
        // R6: every expected result was produced
        for (int i = 0; i < 4; i++)
            check(expq[i].size() == 0, "R6 missing results", 64'(expq[i].size()), 64'h0);
        finish_run();
    end
endmodule